// File: doc/BRIEF.md
# Stall-Merging AND-Transfer Accumulator

This block models, cycle by cycle, the accumulator side of an immediate-mode instruction that moves the X index register into the accumulator while masking it. The result is a wired-AND of three terms. The first is the old accumulator value with a per-use pass mask ORed into it. The second is the X register. The third is every operand byte that the data bus presents during the read cycle. A configuration input named `magic_in` supplies the pass mask. Any bit set in it lets the matching accumulator bit through the AND unconditionally, so values such as FF, FE, EE and 00 model different silicon behaviours.

A `start` pulse captures the accumulator, X and mask values and opens the read cycle. While `ready` is low the cycle is stalled. The byte on the bus in each stalled cycle is still merged into the working value. The final byte, taken in the first cycle with `ready` high, is merged last. The accumulator and the negative and zero flags then update, and `done` pulses for one cycle. Bits 0 and 4 form a direct-feedback group and the other six bits form an adjust-path group. A build-time option clears bit 4 on every stalled cycle, and it touches only the direct-feedback group.

The control is a three-state machine. IDLE goes to READ on `start`. READ stays in READ while `ready` is low, which is the stall transition. READ goes to DONE when `ready` is high, which is the commit transition. DONE always returns to IDLE.

Top module: `xfer_mask_acc`

## Requirements
- R1: After reset, `acc_out` is 00, `neg_flag` is 0, `zero_flag` is 0 and `done` is 0.
- R2: With no stall and the bit-4 option off, the committed `acc_out` equals (`a_in` OR `magic_in`) AND `x_in` AND the bus byte of the commit cycle. `a_in`, `x_in` and `magic_in` are sampled in the `start` cycle.
- R3: Each bus byte present in a cycle where `ready` is low, after the start cycle, is ANDed into the result, so the committed value never has a bit set that X or any stalled byte has clear.
- R4: With `CLR_ON_STALL` set and at least one stalled cycle, bit 4 of the committed result is 0. With it clear, stalls have no effect on bit 4 beyond the AND.
- R5: At commit, `neg_flag` equals bit 7 of the result and `zero_flag` is 1 exactly when the result is 00.
- R6: `done` is high for exactly one cycle: the cycle after the clock edge at which `ready` was high during READ.
- R7: A `start` pulse while an operation is in progress is ignored and does not change the result.
- R8: `acc_out` and the flags change only on the edge that raises `done` and hold their values afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an operation when idle |
| ready | input | 1 | Low stalls the read cycle |
| bus_byte | input | W | Data bus byte sampled every read cycle |
| a_in | input | W | Accumulator value to operate on |
| x_in | input | W | X index register value |
| magic_in | input | W | Accumulator pass mask |
| acc_out | output | W | Committed accumulator |
| neg_flag | output | 1 | Negative flag |
| zero_flag | output | 1 | Zero flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bit-4 clear and the merge of the stalled byte act on the same edge of a stalled cycle. The bench feeds stalled bytes with bit 4 set into two instances built with the option on and off, then compares each committed value to its own independent model. A stray `start` is also driven in the same cycle as a stall. The bench then confirms that the result still reflects the originally captured operands.

// File: rtl/xm_pkg.sv
package xm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_DONE = 2'd2
    } xm_state_e;

    typedef struct packed {
        logic load;
        logic merge;
        logic stall;
        logic commit;
    } xm_ctl_t;

endpackage

// File: rtl/xm_ctrl.sv
module xm_ctrl
    import xm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      ready,
    output xm_state_e state,
    output xm_ctl_t   ctl,
    output logic      done
);

    xm_state_e state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (start) state_nxt = ST_READ;
            ST_READ: if (ready) state_nxt = ST_DONE;
            ST_DONE: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        ctl  = '0;
        done = 1'b0;
        unique case (state)
            ST_IDLE: ctl.load = start;
            ST_READ: begin
                ctl.merge  = 1'b1;
                ctl.stall  = !ready;
                ctl.commit = ready;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/xm_datapath.sv
module xm_datapath
    import xm_pkg::*;
#(
    parameter int           W            = 8,
    parameter logic [W-1:0] DIRECT_MASK  = 8'h11,
    parameter logic [W-1:0] CLEAR_MASK   = 8'h10,
    parameter bit           CLR_ON_STALL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  xm_ctl_t      ctl,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] magic_in,
    input  logic [W-1:0] bus_byte,
    output logic [W-1:0] result_nxt,
    output logic [W-1:0] acc_out
);

    logic [W-1:0] work;
    logic [W-1:0] seed;

    assign seed = (a_in | magic_in) & x_in;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (DIRECT_MASK[i]) begin : g_direct
            logic clr_i;
            assign clr_i = CLR_ON_STALL && CLEAR_MASK[i] && ctl.stall;
            assign result_nxt[i] = ctl.load  ? seed[i] :
                                   ctl.merge ? (work[i] & bus_byte[i] & !clr_i) :
                                               work[i];
        end else begin : g_adjust
            assign result_nxt[i] = ctl.load  ? seed[i] :
                                   ctl.merge ? (work[i] & bus_byte[i]) :
                                               work[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            work    <= '0;
            acc_out <= '0;
        end else begin
            work <= result_nxt;
            if (ctl.commit) acc_out <= result_nxt;
        end
    end

endmodule

// File: rtl/xm_flags.sv
module xm_flags #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         commit,
    input  logic [W-1:0] value,
    output logic         neg_flag,
    output logic         zero_flag
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            neg_flag  <= 1'b0;
            zero_flag <= 1'b0;
        end else if (commit) begin
            neg_flag  <= value[W-1];
            zero_flag <= (value == '0);
        end
    end

endmodule

// File: rtl/xfer_mask_acc.sv
module xfer_mask_acc
    import xm_pkg::*;
#(
    parameter int W            = 8,
    parameter bit CLR_ON_STALL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         ready,
    input  logic [W-1:0] bus_byte,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] magic_in,
    output logic [W-1:0] acc_out,
    output logic         neg_flag,
    output logic         zero_flag,
    output logic         done
);

    localparam logic [W-1:0] DIRECT_MASK = W'(8'h11);
    localparam logic [W-1:0] CLEAR_MASK  = W'(8'h10);

    xm_state_e    state;
    xm_ctl_t      ctl;
    logic [W-1:0] result_nxt;

    xm_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .ready (ready),
        .state (state),
        .ctl   (ctl),
        .done  (done)
    );

    xm_datapath #(
        .W            (W),
        .DIRECT_MASK  (DIRECT_MASK),
        .CLEAR_MASK   (CLEAR_MASK),
        .CLR_ON_STALL (CLR_ON_STALL)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl        (ctl),
        .a_in       (a_in),
        .x_in       (x_in),
        .magic_in   (magic_in),
        .bus_byte   (bus_byte),
        .result_nxt (result_nxt),
        .acc_out    (acc_out)
    );

    xm_flags #(.W(W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (ctl.commit),
        .value     (result_nxt),
        .neg_flag  (neg_flag),
        .zero_flag (zero_flag)
    );

endmodule

// File: rtl/xm_checker.sv
module xm_checker
    import xm_pkg::*;
#(
    parameter int W            = 8,
    parameter bit CLR_ON_STALL = 1'b0
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         ready,
    input logic [W-1:0] x_in,
    input logic [W-1:0] acc_out,
    input logic         neg_flag,
    input logic         zero_flag,
    input logic         done,
    input xm_state_e    state
);

    logic [W-1:0] x_cap;
    logic         stalled_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_cap        <= '0;
            stalled_seen <= 1'b0;
        end else if (state == ST_IDLE && start) begin
            x_cap        <= x_in;
            stalled_seen <= 1'b0;
        end else if (state == ST_READ && !ready) begin
            stalled_seen <= 1'b1;
        end
    end

    assert_result_within_x_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((acc_out & ~x_cap) == '0));

    assert_bit4_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (CLR_ON_STALL && done && stalled_seen) |-> !acc_out[4]);

    assert_flags_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (neg_flag == acc_out[W-1]) && (zero_flag == (acc_out == '0)));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_acc_changes_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc_out) |-> done);

    assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(neg_flag) && $stable(zero_flag)));

endmodule

bind xfer_mask_acc xm_checker #(.W(W), .CLR_ON_STALL(CLR_ON_STALL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ready     (ready),
    .x_in      (x_in),
    .acc_out   (acc_out),
    .neg_flag  (neg_flag),
    .zero_flag (zero_flag),
    .done      (done),
    .state     (state)
);

// File: tb/tb_xfer_mask_acc.sv
module tb_xfer_mask_acc;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       ready = 1'b1;
    logic [7:0] bus_byte = 8'h00;
    logic [7:0] a_in = 8'h00;
    logic [7:0] x_in = 8'h00;
    logic [7:0] magic_in = 8'h00;

    logic [7:0] acc_k, acc_c;
    logic       n_k, z_k, d_k, n_c, z_c, d_c;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    xfer_mask_acc #(.W(8), .CLR_ON_STALL(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
        .bus_byte(bus_byte), .a_in(a_in), .x_in(x_in), .magic_in(magic_in),
        .acc_out(acc_k), .neg_flag(n_k), .zero_flag(z_k), .done(d_k)
    );

    xfer_mask_acc #(.W(8), .CLR_ON_STALL(1'b1)) dut_clr (
        .clk(clk), .rst_n(rst_n), .start(start), .ready(ready),
        .bus_byte(bus_byte), .a_in(a_in), .x_in(x_in), .magic_in(magic_in),
        .acc_out(acc_c), .neg_flag(n_c), .zero_flag(z_c), .done(d_c)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Runs one operation; stalls holds up to four stalled bytes, lowest first.
    task automatic run_op(input logic [7:0] a, input logic [7:0] x, input logic [7:0] m,
                          input logic [31:0] stalls, input int nst, input logic [7:0] imm,
                          input bit stray_start);
        logic [7:0] exp_k, exp_c;
        exp_k = (a | m) & x;
        for (int k = 0; k < nst; k++) exp_k = exp_k & stalls[k*8 +: 8];
        exp_k = exp_k & imm;
        exp_c = exp_k;
        if (nst > 0) exp_c[4] = 1'b0;

        @(negedge clk);
        start = 1'b1; a_in = a; x_in = x; magic_in = m;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < nst; k++) begin
            ready = 1'b0; bus_byte = stalls[k*8 +: 8];
            if (stray_start && k == 0) begin
                start = 1'b1; a_in = 8'hFF; x_in = 8'hFF; magic_in = 8'hFF;
            end
            @(negedge clk);
            start = 1'b0;
            check("R6 no done during stall", {7'b0, d_k}, 8'h00);
        end
        ready = 1'b1; bus_byte = imm;
        @(negedge clk);
        bus_byte = 8'hFF;
        check("R6 done high", {7'b0, d_k}, 8'h01);
        check("R6 done high clr", {7'b0, d_c}, 8'h01);
        if (nst == 0) check("R2 result", acc_k, exp_k);
        else if (stray_start) check("R7 stray start ignored", acc_k, exp_k);
        else check("R3 stalled merge", acc_k, exp_k);
        check("R4 bit4 variant", acc_c, exp_c);
        check("R5 N", {7'b0, n_k}, {7'b0, exp_k[7]});
        check("R5 Z", {7'b0, z_k}, {7'b0, exp_k == 8'h00});
        check("R5 Z clr", {7'b0, z_c}, {7'b0, exp_c == 8'h00});
        @(negedge clk);
        check("R6 done single", {7'b0, d_k}, 8'h00);
        check("R8 acc hold", acc_k, exp_k);
        check("R8 N hold", {7'b0, n_k}, {7'b0, exp_k[7]});
    endtask

    task automatic t_reset();
        check("R1 acc", acc_k, 8'h00);
        check("R1 N", {7'b0, n_k}, 8'h00);
        check("R1 Z", {7'b0, z_k}, 8'h00);
        check("R1 done", {7'b0, d_k}, 8'h00);
        check("R1 acc clr", acc_c, 8'h00);
    endtask

    task automatic t_base();
        run_op(8'h5A, 8'hFF, 8'hEE, 32'h0, 0, 8'hF0, 1'b0);
        run_op(8'h03, 8'hFF, 8'h00, 32'h0, 0, 8'hFF, 1'b0);
        run_op(8'h00, 8'hC3, 8'hFF, 32'h0, 0, 8'hA5, 1'b0);
        run_op(8'h9F, 8'h7E, 8'hFE, 32'h0, 0, 8'hFF, 1'b0);
        run_op(8'hF0, 8'h0F, 8'h00, 32'h0, 0, 8'hFF, 1'b0);
        run_op(8'hFF, 8'hFF, 8'hFF, 32'h0, 0, 8'h90, 1'b0);
    endtask

    task automatic t_stall();
        run_op(8'hFF, 8'hFF, 8'hFF, 32'h0000_00F7, 1, 8'hFF, 1'b0);
        run_op(8'hFF, 8'hFF, 8'h00, 32'h00_3F_FD_FB, 3, 8'hF1, 1'b0);
        run_op(8'h11, 8'h11, 8'hEE, 32'h0000_0011, 1, 8'h11, 1'b0);
        run_op(8'hFF, 8'hFF, 8'hFF, 32'hFF_FF_FF_FF, 4, 8'hFF, 1'b0);
    endtask

    task automatic t_stray_start();
        run_op(8'h00, 8'h3C, 8'h00, 32'h0000_00FF, 1, 8'hFF, 1'b1);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_base();
        t_stall();
        t_stray_start();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule